// File: doc/BRIEF.md
# Triggered Cell Capture Controller

This block records a received ATM cell stream into a capture memory of fixed cell capacity, placing the stored window around a trigger. Cells arrive one byte per valid cycle, and a start-of-cell flag marks the first byte of each cell. The memory itself sits outside the block as a plain RAM macro. The block produces the byte write strobe, the write address and the write data for it. It also turns a logical read position (cell number in arrival order, byte within cell) into the physical RAM address.

An arm command picks one of two capture modes. In manual mode nothing is written until a trigger request arrives. The block then stores the full memory's worth of cells that start after the request. In event mode the block writes every cell into the memory as a ring from the moment it is armed. Four error flags, each with its own enable bit, qualify the cell whose first byte they accompany. The first enabled flag makes that cell the trigger cell. The block keeps a fixed number of older cells ahead of the trigger cell and fills the rest of the memory with cells that follow it.

When the last cell of the window has been written, a done flag rises and all writes stop until the block is armed again. A start pointer is latched, so the read translation always begins at the oldest cell of the window. If an event comes before enough earlier cells exist, the capture still proceeds and a shortfall flag is set.

Top module: `cellcap_buffer`

## Requirements
- R1: After reset the block is neither armed nor done, the shortfall flag is low, and the write strobe stays low.
- R2: In manual mode (arm with `arm_mode`=0), no byte is written before the first start-of-cell that comes after the cycle in which `man_trig` is high. From that cell on, exactly DEPTH_CELLS whole cells are written.
- R3: In event mode (arm with `arm_mode`=1), every cell is written into the ring from arming onward. The first enabled event leaves a window of PRE_CELLS cells before the trigger cell, the trigger cell itself, and DEPTH_CELLS-PRE_CELLS-1 cells after it.
- R4: An event flag counts only when its bit in `evt_en` is 1 (bit 0 cell loss, bit 1 header error, bit 2 PRBS error, bit 3 SN/SNP error) and it is high on the start-of-cell byte. Flags that are disabled have no effect on the window.
- R5: Once a trigger has been taken, further event flags are ignored until the next arm.
- R6: If the event comes before PRE_CELLS cells have been stored, the capture is still taken. The pre-trigger shortfall flag goes high, and the window then starts at the first cell stored after arming.
- R7: Read position (cell i, byte k) maps to RAM address ((start + i) mod DEPTH_CELLS) * CELL_BYTES + k, where start is the slot of the oldest cell in the window. Each cell occupies CELL_BYTES consecutive addresses.
- R8: Done rises on the clock edge that writes the final byte of the window's last cell. Done then holds and no writes occur until an arm command, which clears done and the shortfall flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle arm command; restarts a capture |
| arm_mode | input | 1 | Mode sampled with arm: 0 manual, 1 event |
| man_trig | input | 1 | Manual trigger request |
| evt_flags | input | 4 | Event flags, valid on the start-of-cell byte |
| evt_en | input | 4 | Per-flag enables |
| cell_valid | input | 1 | Byte valid on `cell_byte` |
| cell_sop | input | 1 | Marks the first byte of a cell |
| cell_byte | input | 8 | Cell byte |
| rd_cell | input | SLOT_W | Logical cell number for readout (0 = oldest) |
| rd_byte | input | BYTE_W | Byte within the cell for readout |
| mem_we | output | 1 | RAM write strobe |
| mem_waddr | output | ADDR_W | RAM write address |
| mem_wdata | output | 8 | RAM write data |
| mem_raddr | output | ADDR_W | RAM read address for the readout position |
| cap_armed | output | 1 | A capture is in progress |
| cap_done | output | 1 | Capture complete |
| pre_short | output | 1 | Event accepted with fewer pre-trigger cells than asked |

## Verification
The hardest case to reach is an event trigger after the ring has already wrapped. In that case the oldest retained cell lies in a high slot while the trigger cell sits near slot zero, and the start pointer has to be subtracted modulo the depth. The bench scales the memory down to a dozen cells, so a run of cells longer than the ring fits in a few hundred cycles. It then places the enabled flag past the wrap, puts a disabled flag early and a second enabled flag after the trigger, and reads the whole window back through the address translation against cells whose byte values encode their own sequence number.

// File: rtl/cellcap_pkg.sv
package cellcap_pkg;

  typedef enum logic [2:0] {
    CC_IDLE     = 3'd0,
    CC_MAN_WAIT = 3'd1,
    CC_MAN_GO   = 3'd2,
    CC_EVT_PRE  = 3'd3,
    CC_CAPTURE  = 3'd4,
    CC_DONE     = 3'd5
  } cc_state_e;

endpackage

// File: rtl/cellcap_trig_qual.sv
module cellcap_trig_qual #(
  parameter int N_EVT = 4
) (
  input  logic [N_EVT-1:0] evt_flags,
  input  logic [N_EVT-1:0] evt_en,
  output logic             evt_hit
);

  logic [N_EVT-1:0] masked;

  for (genvar g = 0; g < N_EVT; g++) begin : g_mask
    assign masked[g] = evt_flags[g] & evt_en[g];
  end

  assign evt_hit = |masked;

endmodule

// File: rtl/cellcap_addr_map.sv
module cellcap_addr_map #(
  parameter int DEPTH_CELLS = 1500,
  parameter int CELL_BYTES  = 53,
  parameter int SLOT_W      = 11,
  parameter int BYTE_W      = 6,
  parameter int ADDR_W      = 17
) (
  input  logic [SLOT_W-1:0] base_slot,
  input  logic [SLOT_W-1:0] off_cell,
  input  logic [BYTE_W-1:0] byte_idx,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [SLOT_W:0] DEPTH_V = (SLOT_W+1)'(DEPTH_CELLS);

  logic [SLOT_W:0]   sum;
  logic [SLOT_W:0]   phys;

  always_comb begin
    sum  = {1'b0, base_slot} + {1'b0, off_cell};
    phys = (sum >= DEPTH_V) ? (sum - DEPTH_V) : sum;
    addr = ADDR_W'(phys) * ADDR_W'(CELL_BYTES) + ADDR_W'(byte_idx);
  end

endmodule

// File: rtl/cellcap_seq.sv
module cellcap_seq
  import cellcap_pkg::*;
#(
  parameter int DEPTH_CELLS = 1500,
  parameter int CELL_BYTES  = 53,
  parameter int PRE_CELLS   = 749,
  parameter int SLOT_W      = 11,
  parameter int BYTE_W      = 6,
  parameter int REM_W       = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              arm_mode,
  input  logic              man_trig,
  input  logic              evt_hit,
  input  logic              cell_valid,
  input  logic              cell_sop,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [BYTE_W-1:0] wr_byte,
  output logic [SLOT_W-1:0] start_slot,
  output logic              cap_armed,
  output logic              cap_done,
  output logic              pre_short
);

  localparam int              POST_CELLS = DEPTH_CELLS - PRE_CELLS - 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(DEPTH_CELLS - 1);
  localparam logic [SLOT_W-1:0] PRE_V     = SLOT_W'(PRE_CELLS);
  localparam logic [SLOT_W-1:0] BACK_WRAP = SLOT_W'(DEPTH_CELLS - PRE_CELLS);
  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(CELL_BYTES - 1);
  localparam logic [REM_W-1:0]  REM_FULL  = REM_W'(DEPTH_CELLS);
  localparam logic [REM_W-1:0]  REM_POST  = REM_W'(POST_CELLS + 1);

  cc_state_e         state_q, state_d;
  logic              cell_on_q, cell_on_d;
  logic [BYTE_W-1:0] idx_q, idx_d;
  logic [SLOT_W-1:0] cur_q, cur_d;
  logic [SLOT_W-1:0] nxt_q, nxt_d;
  logic [SLOT_W-1:0] pre_q, pre_d;
  logic [SLOT_W-1:0] start_q, start_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic              short_q, short_d;

  logic sop_v, body_v, last_byte, open_st, start_cell;

  // Byte-level write qualification
  always_comb begin
    sop_v      = cell_valid & cell_sop;
    body_v     = cell_valid & ~cell_sop & cell_on_q & (idx_q != BYTE_LAST);
    last_byte  = body_v & (idx_q == BYTE_LAST - BYTE_W'(1));
    open_st    = (state_q == CC_MAN_GO) | (state_q == CC_EVT_PRE) |
                 (state_q == CC_CAPTURE);
    start_cell = sop_v & open_st;
    wr_en      = start_cell | body_v;
    wr_slot    = sop_v ? nxt_q : cur_q;
    wr_byte    = sop_v ? '0 : idx_q + BYTE_W'(1);
  end

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    cell_on_d = cell_on_q;
    idx_d     = idx_q;
    cur_d     = cur_q;
    nxt_d     = nxt_q;
    pre_d     = pre_q;
    start_d   = start_q;
    rem_d     = rem_q;
    short_d   = short_q;

    if (start_cell) begin
      cell_on_d = 1'b1;
      idx_d     = '0;
      cur_d     = nxt_q;
      nxt_d     = (nxt_q == SLOT_LAST) ? '0 : nxt_q + SLOT_W'(1);
    end else if (sop_v) begin
      cell_on_d = 1'b0;
    end else if (body_v) begin
      idx_d = idx_q + BYTE_W'(1);
      if (last_byte) cell_on_d = 1'b0;
    end

    unique case (state_q)
      CC_MAN_WAIT: if (man_trig) state_d = CC_MAN_GO;
      CC_MAN_GO: begin
        if (sop_v) begin
          state_d = CC_CAPTURE;
          rem_d   = REM_FULL;
        end
      end
      CC_EVT_PRE: begin
        if (sop_v) begin
          if (evt_hit) begin
            state_d = CC_CAPTURE;
            rem_d   = REM_POST;
            if (pre_q == PRE_V) begin
              start_d = (nxt_q >= PRE_V) ? nxt_q - PRE_V : nxt_q + BACK_WRAP;
            end else begin
              start_d = '0;
              short_d = 1'b1;
            end
          end else if (pre_q != PRE_V) begin
            pre_d = pre_q + SLOT_W'(1);
          end
        end
      end
      CC_CAPTURE: begin
        if (last_byte) begin
          rem_d = rem_q - REM_W'(1);
          if (rem_q == REM_W'(1)) state_d = CC_DONE;
        end
      end
      default: ;
    endcase

    if (arm) begin
      state_d   = arm_mode ? CC_EVT_PRE : CC_MAN_WAIT;
      cell_on_d = 1'b0;
      idx_d     = '0;
      nxt_d     = '0;
      pre_d     = '0;
      start_d   = '0;
      rem_d     = '0;
      short_d   = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CC_IDLE;
      cell_on_q <= 1'b0;
      idx_q     <= '0;
      cur_q     <= '0;
      nxt_q     <= '0;
      pre_q     <= '0;
      start_q   <= '0;
      rem_q     <= '0;
      short_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      cell_on_q <= cell_on_d;
      idx_q     <= idx_d;
      cur_q     <= cur_d;
      nxt_q     <= nxt_d;
      pre_q     <= pre_d;
      start_q   <= start_d;
      rem_q     <= rem_d;
      short_q   <= short_d;
    end
  end

  assign start_slot = start_q;
  assign cap_armed  = open_st | (state_q == CC_MAN_WAIT);
  assign cap_done   = (state_q == CC_DONE);
  assign pre_short  = short_q;

endmodule

// File: rtl/cellcap_buffer.sv
module cellcap_buffer #(
  parameter int DEPTH_CELLS = 1500,
  parameter int CELL_BYTES  = 53,
  parameter int PRE_CELLS   = 749,
  parameter int N_EVT       = 4,
  localparam int SLOT_W     = $clog2(DEPTH_CELLS),
  localparam int BYTE_W     = $clog2(CELL_BYTES),
  localparam int ADDR_W     = $clog2(DEPTH_CELLS * CELL_BYTES),
  localparam int REM_W      = $clog2(DEPTH_CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              arm_mode,
  input  logic              man_trig,
  input  logic [N_EVT-1:0]  evt_flags,
  input  logic [N_EVT-1:0]  evt_en,
  input  logic              cell_valid,
  input  logic              cell_sop,
  input  logic [7:0]        cell_byte,
  input  logic [SLOT_W-1:0] rd_cell,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              cap_armed,
  output logic              cap_done,
  output logic              pre_short
);

  logic              evt_hit;
  logic [SLOT_W-1:0] wr_slot;
  logic [BYTE_W-1:0] wr_byte;
  logic [SLOT_W-1:0] start_slot;

  cellcap_trig_qual #(.N_EVT(N_EVT)) u_qual (
    .evt_flags (evt_flags),
    .evt_en    (evt_en),
    .evt_hit   (evt_hit)
  );

  cellcap_seq #(
    .DEPTH_CELLS (DEPTH_CELLS),
    .CELL_BYTES  (CELL_BYTES),
    .PRE_CELLS   (PRE_CELLS),
    .SLOT_W      (SLOT_W),
    .BYTE_W      (BYTE_W),
    .REM_W       (REM_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .arm_mode   (arm_mode),
    .man_trig   (man_trig),
    .evt_hit    (evt_hit),
    .cell_valid (cell_valid),
    .cell_sop   (cell_sop),
    .wr_en      (mem_we),
    .wr_slot    (wr_slot),
    .wr_byte    (wr_byte),
    .start_slot (start_slot),
    .cap_armed  (cap_armed),
    .cap_done   (cap_done),
    .pre_short  (pre_short)
  );

  cellcap_addr_map #(
    .DEPTH_CELLS (DEPTH_CELLS), .CELL_BYTES (CELL_BYTES),
    .SLOT_W (SLOT_W), .BYTE_W (BYTE_W), .ADDR_W (ADDR_W)
  ) u_wmap (
    .base_slot (wr_slot),
    .off_cell  ('0),
    .byte_idx  (wr_byte),
    .addr      (mem_waddr)
  );

  cellcap_addr_map #(
    .DEPTH_CELLS (DEPTH_CELLS), .CELL_BYTES (CELL_BYTES),
    .SLOT_W (SLOT_W), .BYTE_W (BYTE_W), .ADDR_W (ADDR_W)
  ) u_rmap (
    .base_slot (start_slot),
    .off_cell  (rd_cell),
    .byte_idx  (rd_byte),
    .addr      (mem_raddr)
  );

  assign mem_wdata = cell_byte;

endmodule

// File: rtl/cellcap_checker.sv
module cellcap_checker #(
  parameter int DEPTH_CELLS = 1500,
  parameter int CELL_BYTES  = 53,
  parameter int SLOT_W      = 11,
  parameter int BYTE_W      = 6,
  parameter int ADDR_W      = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              cell_sop,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [ADDR_W-1:0] mem_raddr,
  input logic [SLOT_W-1:0] rd_cell,
  input logic [BYTE_W-1:0] rd_byte,
  input logic              cap_armed,
  input logic              cap_done,
  input logic              pre_short
);

  localparam logic [ADDR_W:0] TOTAL   = (ADDR_W+1)'(DEPTH_CELLS * CELL_BYTES);
  localparam logic [SLOT_W:0] DEPTH_V = (SLOT_W+1)'(DEPTH_CELLS);
  localparam logic [BYTE_W:0] CB_V    = (BYTE_W+1)'(CELL_BYTES);

  // R1: nothing written while no capture is open
  a_r1_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_armed |-> !mem_we);

  // R8: done blocks writes and holds until arm; arm clears flags
  a_r8_no_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> !mem_we);
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done && !arm |=> cap_done);
  a_r8_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !cap_done && !pre_short);

  // R7: bytes of a cell land on consecutive addresses
  a_r7_byte_stride: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !cell_sop && $past(mem_we) |-> mem_waddr == $past(mem_waddr) + 1'b1);

  // R7: write and read addresses stay inside the memory
  a_r7_waddr_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> {1'b0, mem_waddr} < TOTAL);
  a_r7_raddr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rd_cell} < DEPTH_V) && ({1'b0, rd_byte} < CB_V) |-> {1'b0, mem_raddr} < TOTAL);

endmodule

bind cellcap_buffer cellcap_checker #(
  .DEPTH_CELLS (DEPTH_CELLS), .CELL_BYTES (CELL_BYTES),
  .SLOT_W (SLOT_W), .BYTE_W (BYTE_W), .ADDR_W (ADDR_W)
) u_chk (
  .clk (clk), .rst_n (rst_n), .arm (arm), .cell_sop (cell_sop),
  .mem_we (mem_we), .mem_waddr (mem_waddr), .mem_raddr (mem_raddr),
  .rd_cell (rd_cell), .rd_byte (rd_byte),
  .cap_armed (cap_armed), .cap_done (cap_done), .pre_short (pre_short)
);

// File: tb/cellcap_buffer_tb.sv
module cellcap_buffer_tb;

  localparam int D   = 12;
  localparam int CB  = 4;
  localparam int PRE = 5;
  localparam int SW  = $clog2(D);
  localparam int BW  = $clog2(CB);
  localparam int AW  = $clog2(D * CB);

  logic          clk, rst_n;
  logic          arm, arm_mode, man_trig;
  logic [3:0]    evt_flags, evt_en;
  logic          cell_valid, cell_sop;
  logic [7:0]    cell_byte;
  logic [SW-1:0] rd_cell;
  logic [BW-1:0] rd_byte;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]    mem_wdata;
  logic          cap_armed, cap_done, pre_short;

  int n_checks = 0;
  int n_errors = 0;
  int wr_count;
  logic [7:0] mem_model [0:D*CB-1];

  cellcap_buffer #(.DEPTH_CELLS(D), .CELL_BYTES(CB), .PRE_CELLS(PRE)) u_dut (
    .clk (clk), .rst_n (rst_n), .arm (arm), .arm_mode (arm_mode),
    .man_trig (man_trig), .evt_flags (evt_flags), .evt_en (evt_en),
    .cell_valid (cell_valid), .cell_sop (cell_sop), .cell_byte (cell_byte),
    .rd_cell (rd_cell), .rd_byte (rd_byte),
    .mem_we (mem_we), .mem_waddr (mem_waddr), .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr), .cap_armed (cap_armed), .cap_done (cap_done),
    .pre_short (pre_short)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // External RAM model and write counter
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_count <= 0;
    else if (mem_we) begin
      mem_model[mem_waddr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic send_cell(input int num, input logic [3:0] fl);
    for (int k = 0; k < CB; k++) begin
      @(negedge clk);
      cell_valid = 1'b1;
      cell_sop   = (k == 0);
      cell_byte  = {num[5:0], k[1:0]};
      evt_flags  = (k == 0) ? fl : 4'b0;
    end
    @(negedge clk);
    cell_valid = 1'b0;
    cell_sop   = 1'b0;
    evt_flags  = 4'b0;
  endtask

  task automatic do_arm(input logic mode);
    @(negedge clk);
    arm = 1'b1;
    arm_mode = mode;
    @(negedge clk);
    arm = 1'b0;
  endtask

  // Read the window back in logical order; cell i must hold sequence base+i
  task automatic check_window(input string req, input int ncells, input int base);
    for (int i = 0; i < ncells; i++) begin
      int bad_got = -1;
      int bad_exp = -1;
      for (int k = 0; k < CB; k++) begin
        logic [7:0] exp_b;
        logic [7:0] got_b;
        int num = base + i;
        @(negedge clk);
        rd_cell = SW'(i);
        rd_byte = BW'(k);
        #1;
        exp_b = {num[5:0], k[1:0]};
        got_b = mem_model[mem_raddr];
        if (got_b !== exp_b && bad_got < 0) begin
          bad_got = int'(got_b);
          bad_exp = int'(exp_b);
        end
      end
      check(req, $sformatf("window cell %0d byte", i), bad_got, bad_exp);
    end
  endtask

  task automatic t_reset;
    check("R1", "cap_armed", int'(cap_armed), 0);
    check("R1", "cap_done", int'(cap_done), 0);
    check("R1", "pre_short", int'(pre_short), 0);
    check("R1", "mem_we", int'(mem_we), 0);
  endtask

  task automatic t_manual;
    int c0;
    do_arm(1'b0);
    check("R2", "armed after manual arm", int'(cap_armed), 1);
    c0 = wr_count;
    for (int n = 40; n < 43; n++) send_cell(n, 4'b0);
    check("R2", "writes before trigger", wr_count - c0, 0);
    @(negedge clk); man_trig = 1'b1;
    @(negedge clk); man_trig = 1'b0;
    for (int n = 0; n < D - 1; n++) send_cell(n, 4'b0);
    check("R8", "done before last cell", int'(cap_done), 0);
    send_cell(D - 1, 4'b0);
    check("R8", "done after last cell", int'(cap_done), 1);
    send_cell(D, 4'b0);
    send_cell(D + 1, 4'b0);
    check("R2", "bytes written in manual capture", wr_count - c0, D * CB);
    check_window("R2", D, 0);
  endtask

  task automatic t_event_wrap;
    evt_en = 4'b0100;
    do_arm(1'b1);
    check("R8", "done cleared by arm", int'(cap_done), 0);
    for (int n = 0; n < 15; n++) send_cell(n, (n == 4) ? 4'b0001 : 4'b0);
    check("R4", "disabled flag made no trigger", int'(cap_done), 0);
    send_cell(15, 4'b0100);
    for (int n = 16; n < 21; n++) send_cell(n, (n == 17) ? 4'b0100 : 4'b0);
    check("R5", "done not yet after cell 20", int'(cap_done), 0);
    send_cell(21, 4'b0);
    check("R3", "done after post window", int'(cap_done), 1);
    check("R3", "no shortfall", int'(pre_short), 0);
    check_window("R3", D, 10);
  endtask

  task automatic t_event_short;
    int c0;
    do_arm(1'b1);
    check("R8", "shortfall cleared by arm", int'(pre_short), 0);
    c0 = wr_count;
    send_cell(0, 4'b0);
    send_cell(1, 4'b0);
    send_cell(2, 4'b1100);
    check("R6", "shortfall flag", int'(pre_short), 1);
    for (int n = 3; n < 9; n++) send_cell(n, 4'b0);
    check("R6", "done after short window", int'(cap_done), 1);
    send_cell(9, 4'b0);
    check("R8", "no writes after done", wr_count - c0, 9 * CB);
    check_window("R6", 9, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    arm = 1'b0; arm_mode = 1'b0; man_trig = 1'b0;
    evt_flags = 4'b0; evt_en = 4'b0;
    cell_valid = 1'b0; cell_sop = 1'b0; cell_byte = 8'h00;
    rd_cell = '0; rd_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_manual();
    t_event_wrap();
    t_event_short();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule